// File: doc/BRIEF.md
# Push-Button Combination Lock

This block is a Moore state machine that opens a lock when a fixed digit code is keyed in on push buttons. Four buttons feed it: one for digit 0, one for digit 1, a Start button and a clear button. Each press arrives already cleaned up: a single-cycle pulse that is stable around exactly one rising clock edge. The block keeps count of how many leading code digits have been matched. It raises `unlock` while the full code has been matched. The default code is 0,1,1,0, and digit i of the code sits in bit i of the `CODE` parameter.

The `USE_START` parameter picks one of two ways of entering the code. With `USE_START=1`, a Start press arms the lock and the digits that follow must match the code exactly. Any mismatch disarms the lock until Start is pressed again. With `USE_START=0`, the Start button plays no part and the lock is a sliding-window matcher. It opens whenever the most recent digits equal the code, and after a wrong digit it falls back to the longest part of the code that is still matched.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `unlock` is 0. The lock is then disarmed (Start mode) or has nothing matched (sliding mode).
- R2: `unlock` is a registered output that depends only on the state. It rises in the cycle after the edge that samples the final code digit. It keeps its value through cycles in which no button pulses.
- R3: With `USE_START=1`, the code unlocks only if Start was the last event before its first digit. Digits entered while disarmed have no effect.
- R4: With `USE_START=1`, a digit that does not match the next code digit disarms the lock. A further digit after the full code has been matched also disarms it. A new Start is needed in both cases.
- R5: With `USE_START=1`, a Start pulse at any time arms the lock with nothing matched and drops `unlock`.
- R6: With `USE_START=0`, `unlock` is 1 exactly when the last four digits since the last clear are 0,1,1,0. `btn_start` has no effect in this mode.
- R7: With `USE_START=0`, a wrong digit leaves the longest code prefix that is a suffix of the digits seen. So 0,1,1,1 leaves nothing matched, and 0,1,0 leaves the first 0 matched, which means 0,1,0,1,1,0 unlocks.
- R8: After an unlock, the next digit pulse drops `unlock`. In sliding mode matching continues from the overlap, so 0,1,1,0 followed by 1,1,0 unlocks again.
- R9: A 0 and a 1 pulse in the same cycle are invalid. They clear the match (disarming in Start mode) and drop `unlock`, even when Start pulses in the same cycle.
- R10: `btn_reset` clears the machine exactly as `rst` does. It takes priority over every other button.
- R11: With `USE_START=1`, when Start and a single digit pulse together, Start wins: the lock arms with nothing matched and the digit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_zero | input | 1 | One-cycle pulse for digit 0 |
| btn_one | input | 1 | One-cycle pulse for digit 1 |
| btn_start | input | 1 | One-cycle Start pulse (used only when USE_START=1) |
| btn_reset | input | 1 | One-cycle clear-button pulse |
| unlock | output | 1 | High while the full code is matched |

## Verification
The bench runs the two modes side by side on the same pulse stream and compares each against an independent model. The Start-mode model keeps the digits typed since the last Start; the sliding model keeps the last four digits. The directed cases include the following:
- 0,1,0,1,1,0: a matcher that drops to nothing on a wrong digit would miss this unlock.
- 0,1,1,1: a matcher that keeps a stale prefix would not clear here.
- Re-unlocking from the overlap after 0,1,1,0,1,1,0.
- Codes typed without Start, or after a Start and a wrong digit, which a design without the arming gate would accept.
- Start and a digit in the same cycle, where a design that lets the digit through would open one digit early.
- Both digits in the same cycle, which a design giving one digit priority would count as a digit.

A long random run then checks every cycle for unlocks that come late, never come, or stick.

// File: rtl/lock_pkg.sv
package lock_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_ZERO,
    EV_ONE,
    EV_START,
    EV_CLEAR
  } lock_event_e;

  // Longest prefix of the code that is a suffix of (code[0..s-1], d).
  function automatic int overlap_next(input logic [15:0] code, input int len,
                                      input int s, input int d);
    int best;
    best = 0;
    for (int k = 1; k <= 16; k++) begin
      if (k <= len && k <= s + 1) begin
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
          if (i < k) begin
            int  pos;
            logic sym;
            pos = s + 1 - k + i;
            sym = (pos == s) ? d[0] : code[pos];
            if (sym != code[i]) ok = 1'b0;
          end
        end
        if (ok) best = k;
      end
    end
    return best;
  endfunction

endpackage

// File: rtl/lock_event_decode.sv
module lock_event_decode #(
  parameter bit USE_START = 1'b1
) (
  input  logic                 btn_zero,
  input  logic                 btn_one,
  input  logic                 btn_start,
  input  logic                 btn_reset,
  output lock_pkg::lock_event_e ev
);
  import lock_pkg::*;

  // Priority: clear button, invalid double digit, Start, single digit.
  always_comb begin
    if (btn_reset)                   ev = EV_CLEAR;
    else if (btn_zero && btn_one)    ev = EV_CLEAR;
    else if (USE_START && btn_start) ev = EV_START;
    else if (btn_zero)               ev = EV_ZERO;
    else if (btn_one)                ev = EV_ONE;
    else                             ev = EV_NONE;
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state #(
  parameter int                  CODE_LEN  = 4,
  parameter logic [CODE_LEN-1:0] CODE      = 4'b0110,
  parameter bit                  USE_START = 1'b1,
  parameter int                  CW        = $clog2(CODE_LEN + 1)
) (
  input  logic                  armed,
  input  logic [CW-1:0]         count,
  input  lock_pkg::lock_event_e ev,
  output logic                  nxt_armed,
  output logic [CW-1:0]         nxt_count
);
  import lock_pkg::*;

  localparam int   SLOTS      = 1 << CW;
  localparam logic IDLE_ARMED = !USE_START;

  // Per-state successor for digit 0 and digit 1, plus a match flag.
  logic [CW-1:0] tab0 [SLOTS];
  logic [CW-1:0] tab1 [SLOTS];
  logic          hit0 [SLOTS];
  logic          hit1 [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_tab
    if (s >= CODE_LEN) begin : g_end
      // Full match (or unreachable slot): strict mode disarms here.
      if (!USE_START && s == CODE_LEN) begin : g_wrap
        localparam int N0 = overlap_next(16'(CODE), CODE_LEN, s, 0);
        localparam int N1 = overlap_next(16'(CODE), CODE_LEN, s, 1);
        assign tab0[s] = CW'(N0);
        assign tab1[s] = CW'(N1);
      end else begin : g_zero
        assign tab0[s] = '0;
        assign tab1[s] = '0;
      end
      assign hit0[s] = 1'b0;
      assign hit1[s] = 1'b0;
    end else if (USE_START) begin : g_strict
      assign hit0[s] = !CODE[s];
      assign hit1[s] =  CODE[s];
      assign tab0[s] = CW'(s + 1);
      assign tab1[s] = CW'(s + 1);
    end else begin : g_slide
      localparam int N0 = overlap_next(16'(CODE), CODE_LEN, s, 0);
      localparam int N1 = overlap_next(16'(CODE), CODE_LEN, s, 1);
      assign hit0[s] = 1'b1;
      assign hit1[s] = 1'b1;
      assign tab0[s] = CW'(N0);
      assign tab1[s] = CW'(N1);
    end
  end

  always_comb begin
    nxt_armed = armed;
    nxt_count = count;
    unique case (ev)
      EV_CLEAR: begin
        nxt_armed = IDLE_ARMED;
        nxt_count = '0;
      end
      EV_START: begin
        nxt_armed = 1'b1;
        nxt_count = '0;
      end
      EV_ZERO: begin
        if (armed) begin
          if (hit0[count] || !USE_START) begin
            nxt_count = tab0[count];
          end else begin
            nxt_armed = IDLE_ARMED;
            nxt_count = '0;
          end
        end
      end
      EV_ONE: begin
        if (armed) begin
          if (hit1[count] || !USE_START) begin
            nxt_count = tab1[count];
          end else begin
            nxt_armed = IDLE_ARMED;
            nxt_count = '0;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg #(
  parameter int CODE_LEN  = 4,
  parameter bit USE_START = 1'b1,
  parameter int CW        = $clog2(CODE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nxt_armed,
  input  logic [CW-1:0] nxt_count,
  output logic          armed,
  output logic [CW-1:0] count,
  output logic          unlock
);
  localparam logic [CW-1:0] FULL = CW'(CODE_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= !USE_START;
      count  <= '0;
      unlock <= 1'b0;
    end else begin
      armed  <= nxt_armed;
      count  <= nxt_count;
      unlock <= nxt_armed && (nxt_count == FULL);
    end
  end
endmodule

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int                  CODE_LEN  = 4,
  parameter logic [CODE_LEN-1:0] CODE      = 4'b0110,
  parameter bit                  USE_START = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_zero,
  input  logic btn_one,
  input  logic btn_start,
  input  logic btn_reset,
  output logic unlock
);
  localparam int CW = $clog2(CODE_LEN + 1);

  lock_pkg::lock_event_e ev;
  logic          armed, nxt_armed;
  logic [CW-1:0] count, nxt_count;

  lock_event_decode #(.USE_START(USE_START)) u_dec (
    .btn_zero (btn_zero),
    .btn_one  (btn_one),
    .btn_start(btn_start),
    .btn_reset(btn_reset),
    .ev       (ev)
  );

  lock_next_state #(
    .CODE_LEN (CODE_LEN),
    .CODE     (CODE),
    .USE_START(USE_START),
    .CW       (CW)
  ) u_nxt (
    .armed    (armed),
    .count    (count),
    .ev       (ev),
    .nxt_armed(nxt_armed),
    .nxt_count(nxt_count)
  );

  lock_state_reg #(
    .CODE_LEN (CODE_LEN),
    .USE_START(USE_START),
    .CW       (CW)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .nxt_armed(nxt_armed),
    .nxt_count(nxt_count),
    .armed    (armed),
    .count    (count),
    .unlock   (unlock)
  );
endmodule

// File: rtl/lock_checker.sv
module lock_checker #(
  parameter int                  CODE_LEN  = 4,
  parameter logic [CODE_LEN-1:0] CODE      = 4'b0110,
  parameter bit                  USE_START = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic btn_zero,
  input logic btn_one,
  input logic btn_start,
  input logic btn_reset,
  input logic unlock
);
  logic last_digit_alone;
  logic quiet;
  assign last_digit_alone = (CODE[CODE_LEN-1] ? (btn_one && !btn_zero)
                                              : (btn_zero && !btn_one))
                            && !btn_reset && !(USE_START && btn_start);
  assign quiet = !btn_zero && !btn_one && !btn_reset
                 && !(USE_START && btn_start);

  assert_rise_after_digit_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> $past(last_digit_alone));

  assert_hold_when_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    quiet |=> $stable(unlock));

  assert_double_digit_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (btn_zero && btn_one) |=> !unlock);

  assert_clear_button_R10: assert property (@(posedge clk) disable iff (rst)
    btn_reset |=> !unlock);

  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !unlock);

  if (USE_START) begin : g_start
    assert_start_restarts_R5: assert property (@(posedge clk) disable iff (rst)
      btn_start |=> !unlock);
  end
endmodule

bind combo_lock lock_checker #(
  .CODE_LEN (CODE_LEN),
  .CODE     (CODE),
  .USE_START(USE_START)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .btn_zero (btn_zero),
  .btn_one  (btn_one),
  .btn_start(btn_start),
  .btn_reset(btn_reset),
  .unlock   (unlock)
);

// File: tb/sim_combo_lock.sv
module sim_combo_lock;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bz = 1'b0, bo = 1'b0, bs = 1'b0, br = 1'b0;
  logic unl_s, unl_w;
  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  combo_lock #(.USE_START(1'b1)) u0 (
    .clk(clk), .rst(rst), .btn_zero(bz), .btn_one(bo),
    .btn_start(bs), .btn_reset(br), .unlock(unl_s));

  combo_lock #(.USE_START(1'b0)) u1 (
    .clk(clk), .rst(rst), .btn_zero(bz), .btn_one(bo),
    .btn_start(bs), .btn_reset(br), .unlock(unl_w));

  // Start-mode model: digits typed since the last Start.
  bit       s_valid;
  int       s_len;
  bit [3:0] s_seq;
  // Sliding model: last four digits since last clear.
  int       w_cnt;
  bit [3:0] w_hist;

  function automatic bit exp_s();
    return s_valid && s_len == 4 && s_seq == 4'b0110;
  endfunction
  function automatic bit exp_w();
    return w_cnt >= 4 && w_hist == 4'b0110;
  endfunction

  task automatic model_clear();
    s_valid = 1'b0; s_len = 0; s_seq = '0;
    w_cnt = 0; w_hist = '0;
  endtask

  task automatic check(input logic act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: unlock=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at next fall.
  task automatic apply(input bit z, input bit o, input bit s, input bit b,
                       input string tag_s, input string tag_w);
    bz = z; bo = o; bs = s; br = b;
    @(posedge clk);
    if (b || (z && o)) begin
      model_clear();
    end else begin
      if (s) begin
        s_valid = 1'b1; s_len = 0; s_seq = '0;
      end else if ((z || o) && s_valid && s_len < 5) begin
        s_seq = {s_seq[2:0], o}; s_len++;
      end
      if (z || o) begin
        w_hist = {w_hist[2:0], o};
        if (w_cnt < 4) w_cnt++;
      end
    end
    @(negedge clk);
    bz = 1'b0; bo = 1'b0; bs = 1'b0; br = 1'b0;
    check(unl_s, exp_s(), tag_s);
    check(unl_w, exp_w(), tag_w);
  endtask

  task automatic digits(input bit [3:0] code, input int n,
                        input string ts, input string tw);
    for (int i = n - 1; i >= 0; i--) apply(!code[i], code[i], 0, 0, ts, tw);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(unl_s, 1'b0, "R1");
    check(unl_w, 1'b0, "R1");
    @(negedge clk);
    check(unl_s, 1'b0, "R1");

    // Start then code; idle holds.
    apply(0, 0, 1, 0, "R5", "R6");
    digits(4'b0110, 4, "R3", "R6");
    check(unl_s, 1'b1, "R3");
    check(unl_w, 1'b1, "R6");
    apply(0, 0, 0, 0, "R2", "R2");
    apply(0, 0, 0, 0, "R2", "R2");
    // Next digit drops unlock; sliding re-unlocks from overlap.
    digits(4'b0110, 1, "R8", "R8");
    digits(4'b0110, 3, "R4", "R8");
    check(unl_w, 1'b1, "R8");
    // Double digit clears.
    apply(1, 1, 0, 0, "R9", "R9");
    // Code without Start does nothing in Start mode.
    digits(4'b0110, 4, "R3", "R6");
    check(unl_s, 1'b0, "R3");
    // 0,1,1,1 leaves nothing; 0,1,0,1,1,0 unlocks sliding.
    apply(1, 1, 0, 0, "R9", "R9");
    apply(0, 0, 1, 0, "R5", "R6");
    digits(4'b0111, 4, "R4", "R7");
    digits(4'b0110, 3, "R4", "R7");
    check(unl_w, 1'b0, "R7");
    apply(1, 1, 0, 0, "R9", "R9");
    digits(4'b0010, 3, "R3", "R7");
    digits(4'b0110, 3, "R3", "R7");
    check(unl_w, 1'b1, "R7");
    // Start mid-sequence restarts; Start ignored by sliding lock.
    apply(0, 0, 1, 0, "R5", "R6");
    digits(4'b0001, 2, "R5", "R6");
    apply(0, 0, 1, 0, "R5", "R6");
    digits(4'b0110, 4, "R5", "R6");
    check(unl_s, 1'b1, "R5");
    apply(0, 0, 1, 0, "R5", "R6");
    check(unl_w, 1'b1, "R6");
    check(unl_s, 1'b0, "R5");
    // Start with digit: digit discarded in Start mode.
    apply(0, 1, 1, 0, "R11", "R6");
    digits(4'b0110, 4, "R11", "R6");
    check(unl_s, 1'b1, "R11");
    // Clear button when unlocked.
    apply(0, 0, 0, 1, "R10", "R10");
    check(unl_s, 1'b0, "R10");
    // Both digits with Start: invalid wins.
    apply(1, 1, 1, 0, "R9", "R9");
    digits(4'b0110, 4, "R9", "R6");
    check(unl_s, 1'b0, "R9");
    // rst mid-run.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    check(unl_w, 1'b0, "R1");

    // Random pulse stream.
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2)       apply(0, 0, 0, 1, "R10", "R10");
      else if (r < 5)  apply(1, 1, 0, 0, "R9", "R9");
      else if (r < 15) apply(0, 0, 1, 0, "R5", "R6");
      else if (r < 50) apply(1, 0, 0, 0, "R4", "R7");
      else if (r < 85) apply(0, 1, 0, 0, "R4", "R7");
      else if (r < 90) apply(0, 1, 1, 0, "R11", "R6");
      else             apply(0, 0, 0, 0, "R2", "R2");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule